// File: doc/BRIEF.md
# Parallel RGB LCD Timing Generator

This block drives the control side of a parallel RGB panel. It produces the horizontal sync, the vertical sync, a data-enable that marks visible pixels and a pixel strobe. These are derived from a small set of programmable timing registers and a source clock divided by a programmable ratio. Each frame runs sync, back porch, active and front porch, first in pixels along a line and then in lines down the frame. A frame interrupt flags the start of every vertical sync.

Software first programs the porch, sync and size registers while the generator is stopped. It then sets the run bit. The data-enable is gated by a frame-synchronous enable, which is sampled only at frame boundaries, so a panel never sees a partial frame. Clearing the run bit stops all outputs on the next cycle. The inversion of each output is chosen on its own.

Top module: `lcd_timing_gen`

## Requirements
- R1: Register 2 holds horizontal timings as value minus one: sync width in [7:0], back porch in [15:8], front porch in [23:16]. Register 4 [10:0] holds active width minus one. A line is sync, back porch, active, front porch, counted in pixel strobes, and the raw hsync is high during the sync part.
- R2: Register 3 holds vertical timings with the same field positions, counted in lines. Register 4 [26:16] holds active line count minus one. The raw vsync is high during the sync lines.
- R3: The raw data-enable is high only when the pixel and line counters are both in their active regions and the frame enable in force is set.
- R4: Register 1 selects output inversion: [0] vsync, [1] hsync, [2] data-enable, [3] vclk. Each output is its raw value XOR its bit, so a stopped generator shows the inverted idle level.
- R5: Register 0 [15:8] is the divide ratio minus one. A pixel strobe (pclk_en_o, and vclk_o before inversion) occurs once every ratio source clocks, with the first strobe on the first running cycle. A field value of 0 gives a strobe on every clock.
- R6: A divider field written above 254 is stored and read back as 254, so the ratio never exceeds 255.
- R7: Register 0 [1] is the frame enable. Its value is taken into force only at the start of a frame (run start or wrap to line 0), so a change mid-frame leaves the current frame's data-enable unchanged.
- R8: Register 0 [0] is run. While it is clear, the pixel strobe and the raw syncs and data-enable are low from the next cycle on. A new run starts from pixel 0, line 0.
- R9: Register 5 [0] is the frame interrupt. It is set at each frame start and drives irq_o one cycle later. Writing 1 to the bit clears it, and writing 0 has no effect.
- R10: After reset all registers read 0, every output is low and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of register at addr_i |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data-enable after polarity |
| vclk_o | output | 1 | Pixel clock strobe after polarity |
| pclk_en_o | output | 1 | Pixel clock enable, never inverted |
| irq_o | output | 1 | Frame interrupt pending |

## Verification
The bench builds the block with its default widths (8-bit porch fields, 11-bit size fields, 8-bit divider). It programs a tiny frame of 11 pixels by 7 lines, so whole frames and several wraps fit in a few hundred cycles. It runs divide ratios 1, 3 and the clamped 255. That brings the frame-boundary sampling of the enable, the stop and restart path and the interrupt set-versus-clear ordering within reach of a short run.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL = 3'd0,
    RA_POL  = 3'd1,
    RA_HTIM = 3'd2,
    RA_VTIM = 3'd3,
    RA_SIZE = 3'd4,
    RA_IRQ  = 3'd5
  } reg_addr_e;

  // bit order matches the polarity register layout
  typedef struct packed {
    logic clk;
    logic de;
    logic hs;
    logic vs;
  } pol_t;

  localparam int unsigned CTRL_RUN_BIT  = 0;
  localparam int unsigned CTRL_RUNF_BIT = 1;
  localparam int unsigned CTRL_DIV_LSB  = 8;
  localparam int unsigned SIZE_V_LSB    = 16;
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
  import lcd_tg_pkg::*;
#(
  parameter int unsigned PORCH_W = 8,
  parameter int unsigned SIZE_W  = 11,
  parameter int unsigned DIV_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                frame_start_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                run_o,
  output logic                run_f_o,
  output logic [DIV_W-1:0]    div_o,
  output pol_t                pol_o,
  output logic [PORCH_W-1:0]  sw_o  [2],
  output logic [PORCH_W-1:0]  bp_o  [2],
  output logic [PORCH_W-1:0]  fp_o  [2],
  output logic [SIZE_W-1:0]   act_o [2],
  output logic                irq_o
);
  localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'((1 << DIV_W) - 2);

  logic [DIV_W-1:0] div_wr;
  logic             irq_clr;

  assign div_wr  = (wdata_i[CTRL_DIV_LSB +: DIV_W] > DIV_MAX) ? DIV_MAX
                                                               : wdata_i[CTRL_DIV_LSB +: DIV_W];
  assign irq_clr = wr_en_i && (addr_i == RA_IRQ) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o   <= 1'b0;
      run_f_o <= 1'b0;
      div_o   <= '0;
      pol_o   <= '0;
      for (int a = 0; a < 2; a++) begin
        sw_o[a]  <= '0;
        bp_o[a]  <= '0;
        fp_o[a]  <= '0;
        act_o[a] <= '0;
      end
    end else if (wr_en_i) begin
      case (addr_i)
        RA_CTRL: begin
          run_o   <= wdata_i[CTRL_RUN_BIT];
          run_f_o <= wdata_i[CTRL_RUNF_BIT];
          div_o   <= div_wr;
        end
        RA_POL:  pol_o <= pol_t'(wdata_i[3:0]);
        RA_HTIM: begin
          sw_o[0] <= wdata_i[0 +: PORCH_W];
          bp_o[0] <= wdata_i[PORCH_W +: PORCH_W];
          fp_o[0] <= wdata_i[2*PORCH_W +: PORCH_W];
        end
        RA_VTIM: begin
          sw_o[1] <= wdata_i[0 +: PORCH_W];
          bp_o[1] <= wdata_i[PORCH_W +: PORCH_W];
          fp_o[1] <= wdata_i[2*PORCH_W +: PORCH_W];
        end
        RA_SIZE: begin
          act_o[0] <= wdata_i[0 +: SIZE_W];
          act_o[1] <= wdata_i[SIZE_V_LSB +: SIZE_W];
        end
        default: ;
      endcase
    end
  end

  // frame start wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            irq_o <= 1'b0;
    else if (frame_start_i) irq_o <= 1'b1;
    else if (irq_clr)       irq_o <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CTRL: begin
        rdata_o[CTRL_RUN_BIT]              = run_o;
        rdata_o[CTRL_RUNF_BIT]             = run_f_o;
        rdata_o[CTRL_DIV_LSB +: DIV_W]     = div_o;
      end
      RA_POL:  rdata_o[3:0] = pol_o;
      RA_HTIM: begin
        rdata_o[0 +: PORCH_W]          = sw_o[0];
        rdata_o[PORCH_W +: PORCH_W]    = bp_o[0];
        rdata_o[2*PORCH_W +: PORCH_W]  = fp_o[0];
      end
      RA_VTIM: begin
        rdata_o[0 +: PORCH_W]          = sw_o[1];
        rdata_o[PORCH_W +: PORCH_W]    = bp_o[1];
        rdata_o[2*PORCH_W +: PORCH_W]  = fp_o[1];
      end
      RA_SIZE: begin
        rdata_o[0 +: SIZE_W]           = act_o[0];
        rdata_o[SIZE_V_LSB +: SIZE_W]  = act_o[1];
      end
      RA_IRQ:  rdata_o[0] = irq_o;
      default: ;
    endcase
  end
endmodule

// File: rtl/lcd_tg_clkdiv.sv
module lcd_tg_clkdiv #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q >= div_i)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
  parameter int unsigned PORCH_W = 8,
  parameter int unsigned SIZE_W  = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               step_i,
  input  logic [PORCH_W-1:0] sw_i,
  input  logic [PORCH_W-1:0] bp_i,
  input  logic [PORCH_W-1:0] fp_i,
  input  logic [SIZE_W-1:0]  act_i,
  output logic               sync_o,
  output logic               active_o,
  output logic               last_o
);
  localparam int unsigned CNT_W = ((SIZE_W > PORCH_W) ? SIZE_W : PORCH_W) + 3;

  logic [CNT_W-1:0] cnt_q, sync_end, act_beg, act_end, last_val;

  // fields are minus-one: each segment length is field + 1
  assign sync_end = CNT_W'(sw_i) + 1'b1;
  assign act_beg  = sync_end + CNT_W'(bp_i) + 1'b1;
  assign act_end  = act_beg + CNT_W'(act_i) + 1'b1;
  assign last_val = act_end + CNT_W'(fp_i);

  assign sync_o   = cnt_q < sync_end;
  assign active_o = (cnt_q >= act_beg) && (cnt_q < act_end);
  assign last_o   = cnt_q == last_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= (cnt_q >= last_val) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int unsigned PORCH_W = 8,
  parameter int unsigned SIZE_W  = 11,
  parameter int unsigned DIV_W   = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        de_o,
  output logic        vclk_o,
  output logic        pclk_en_o,
  output logic        irq_o
);
  logic               run, run_f, run_q, live_q, tick, frame_start;
  logic [DIV_W-1:0]   div;
  pol_t               pol;
  logic [PORCH_W-1:0] sw [2];
  logic [PORCH_W-1:0] bp [2];
  logic [PORCH_W-1:0] fp [2];
  logic [SIZE_W-1:0]  act [2];
  logic [1:0]         ax_sync, ax_act, ax_last, ax_step;
  logic               hs_raw, vs_raw, de_raw;

  lcd_tg_regs #(.PORCH_W(PORCH_W), .SIZE_W(SIZE_W), .DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .frame_start_i(frame_start),
    .rdata_o,
    .run_o(run), .run_f_o(run_f), .div_o(div), .pol_o(pol),
    .sw_o(sw), .bp_o(bp), .fp_o(fp), .act_o(act),
    .irq_o
  );

  lcd_tg_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .run_i(run), .div_i(div), .tick_o(tick)
  );

  // axis 0 counts pixels, axis 1 counts lines
  assign ax_step[0] = tick;
  assign ax_step[1] = tick && ax_last[0];

  for (genvar g = 0; g < 2; g++) begin : g_axis
    lcd_tg_axis #(.PORCH_W(PORCH_W), .SIZE_W(SIZE_W)) u_axis (
      .clk_i, .rst_ni,
      .clear_i(!run),
      .step_i(ax_step[g]),
      .sw_i(sw[g]), .bp_i(bp[g]), .fp_i(fp[g]), .act_i(act[g]),
      .sync_o(ax_sync[g]), .active_o(ax_act[g]), .last_o(ax_last[g])
    );
  end

  assign frame_start = run && (!run_q || (tick && ax_last[0] && ax_last[1]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      run_q <= run;
      if (frame_start) live_q <= run_f;
    end
  end

  assign hs_raw = run && ax_sync[0];
  assign vs_raw = run && ax_sync[1];
  assign de_raw = run && live_q && ax_act[0] && ax_act[1];

  assign hsync_o   = hs_raw ^ pol.hs;
  assign vsync_o   = vs_raw ^ pol.vs;
  assign de_o      = de_raw ^ pol.de;
  assign vclk_o    = tick ^ pol.clk;
  assign pclk_en_o = tick;
endmodule

// File: rtl/lcd_tg_chk.sv
module lcd_tg_chk #(
  parameter int unsigned DIV_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic [DIV_W-1:0] div_i,
  input logic             hs_raw_i,
  input logic             vs_raw_i,
  input logic             de_raw_i,
  input logic             pclk_en_i,
  input logic             irq_i,
  input logic             wr_en_i,
  input logic [2:0]       addr_i,
  input logic             wdata0_i
);
  localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'((1 << DIV_W) - 2);

  a_r3_de_outside_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_raw_i |-> (!hs_raw_i && !vs_raw_i));

  a_r8_idle_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (!pclk_en_i && !hs_raw_i && !vs_raw_i && !de_raw_i));

  a_r5_ratio_one_every_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && div_i == '0 && $past(div_i) == '0) |-> pclk_en_i);

  a_r6_div_clamped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_i <= DIV_MAX);

  a_r9_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !(wr_en_i && addr_i == 3'd5 && wdata0_i)) |=> irq_i);
endmodule

bind lcd_timing_gen lcd_tg_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .div_i(div),
  .hs_raw_i(hs_raw), .vs_raw_i(vs_raw), .de_raw_i(de_raw),
  .pclk_en_i(pclk_en_o), .irq_i(irq_o),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata0_i(wdata_i[0])
);

// File: tb/sim_lcd_timing_gen.sv
`timescale 1ns/1ps
module sim_lcd_timing_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic hsync_o, vsync_o, de_o, vclk_o, pclk_en_o, irq_o;

  int tests = 0, fails = 0;
  bit chk_on = 1'b0;

  always #2 clk_i = ~clk_i;

  lcd_timing_gen u0 (.*);

  // ---- behavioural reference ----
  int m_run, m_runf, m_div, m_pol, m_runq, m_live, m_irq, m_dc, m_h, m_v;
  int m_hsw, m_hbp, m_hfp, m_vsw, m_vbp, m_vfp, m_hact, m_vact;

  task automatic m_reset();
    m_run = 0; m_runf = 0; m_div = 0; m_pol = 0; m_runq = 0; m_live = 0;
    m_irq = 0; m_dc = 0; m_h = 0; m_v = 0;
    m_hsw = 1; m_hbp = 1; m_hfp = 1; m_vsw = 1; m_vbp = 1; m_vfp = 1;
    m_hact = 1; m_vact = 1;
  endtask

  initial m_reset();

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_reset();
    else begin
      int htot, vtot, div;
      bit tick, hl, vl, fs;
      htot = m_hsw + m_hbp + m_hact + m_hfp;
      vtot = m_vsw + m_vbp + m_vact + m_vfp;
      tick = m_run != 0 && m_dc == 0;
      hl = m_h == htot - 1;
      vl = m_v == vtot - 1;
      fs = m_run != 0 && (m_runq == 0 || (tick && hl && vl));
      if (fs) m_live = m_runf;
      if (fs) m_irq = 1;
      else if (wr_en_i && addr_i == 3'd5 && wdata_i[0]) m_irq = 0;
      if (m_run == 0) begin
        m_dc = 0; m_h = 0; m_v = 0;
      end else begin
        m_dc = (m_dc >= m_div) ? 0 : m_dc + 1;
        if (tick) begin
          if (hl) begin m_h = 0; m_v = vl ? 0 : m_v + 1; end
          else m_h = m_h + 1;
        end
      end
      m_runq = m_run;
      if (wr_en_i) begin
        case (addr_i)
          3'd0: begin
            m_run = wdata_i[0]; m_runf = wdata_i[1];
            div = int'(wdata_i[15:8]);
            m_div = (div > 254) ? 254 : div;
          end
          3'd1: m_pol = int'(wdata_i[3:0]);
          3'd2: begin m_hsw = wdata_i[7:0] + 1; m_hbp = wdata_i[15:8] + 1; m_hfp = wdata_i[23:16] + 1; end
          3'd3: begin m_vsw = wdata_i[7:0] + 1; m_vbp = wdata_i[15:8] + 1; m_vfp = wdata_i[23:16] + 1; end
          3'd4: begin m_hact = wdata_i[10:0] + 1; m_vact = wdata_i[26:16] + 1; end
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input bit ok, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison
  always @(negedge clk_i) begin
    if (chk_on) begin
      bit run, pe, hs, vs, de;
      run = m_run != 0;
      pe  = run && m_dc == 0;
      hs  = run && m_h < m_hsw;
      vs  = run && m_v < m_vsw;
      de  = run && m_live != 0 &&
            m_h >= m_hsw + m_hbp && m_h < m_hsw + m_hbp + m_hact &&
            m_v >= m_vsw + m_vbp && m_v < m_vsw + m_vbp + m_vact;
      check("R1 hsync",   hsync_o   == (hs ^ m_pol[1]), hsync_o, hs ^ m_pol[1]);
      check("R2 vsync",   vsync_o   == (vs ^ m_pol[0]), vsync_o, vs ^ m_pol[0]);
      check("R3 de",      de_o      == (de ^ m_pol[2]), de_o,    de ^ m_pol[2]);
      check("R5 vclk",    vclk_o    == (pe ^ m_pol[3]), vclk_o,  pe ^ m_pol[3]);
      check("R5 pclk_en", pclk_en_o == pe,              pclk_en_o, pe);
      check("R9 irq",     irq_o     == (m_irq != 0),    irq_o,   m_irq);
    end
  end

  // ---- stimulus helpers (called aligned to a falling edge) ----
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr_i = a;
    #0.5;
    d = rdata_o;
    @(negedge clk_i);
  endtask

  task automatic count_win(input int n, output int c_hs, output int c_vs,
                           output int c_de, output int c_pe, output int c_ck);
    c_hs = 0; c_vs = 0; c_de = 0; c_pe = 0; c_ck = 0;
    repeat (n) begin
      @(negedge clk_i);
      c_hs += hsync_o; c_vs += vsync_o; c_de += de_o; c_pe += pclk_en_o; c_ck += vclk_o;
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  // frame: h = 2 sync + 1 bp + 6 act + 2 fp = 11, v = 1 + 1 + 4 + 1 = 7 lines
  localparam logic [31:0] HTIM = 32'h0001_0001;
  localparam logic [31:0] VTIM = 32'h0000_0000;
  localparam logic [31:0] SIZE = 32'h0003_0005;

  initial begin
    logic [31:0] d;
    int hs, vs, de, pe, ck;
    repeat (3) @(negedge clk_i);
    // R10 reset state
    check("R10 hsync", hsync_o == 0, hsync_o, 0);
    check("R10 vsync", vsync_o == 0, vsync_o, 0);
    check("R10 de",    de_o == 0,    de_o,    0);
    check("R10 irq",   irq_o == 0,   irq_o,   0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R10 reg reset", d == 0, int'(d), 0);
    end
    chk_on = 1'b1;

    wr(3'd2, HTIM); wr(3'd3, VTIM); wr(3'd4, SIZE);
    // run, frame enable, ratio 1
    wr(3'd0, 32'h0000_0003);
    count_win(154, hs, vs, de, pe, ck);
    check("R1 hsync cycles in two frames", hs == 28, hs, 28);
    check("R2 vsync cycles in two frames", vs == 22, vs, 22);
    check("R3 de cycles in two frames",    de == 48, de, 48);
    check("R5 ratio 1 strobes",            pe == 154, pe, 154);

    // R7: drop frame enable mid-run, data-enable stops only at next frame
    repeat (30) @(negedge clk_i);
    wr(3'd0, 32'h0000_0001);
    repeat (100) @(negedge clk_i);
    count_win(154, hs, vs, de, pe, ck);
    check("R7 de off after frame boundary", de == 0, de, 0);

    // R8 stop, then interrupt clear behaviour with nothing running
    wr(3'd0, 32'h0000_0000);
    check("R8 pclk stopped", pclk_en_o == 0, pclk_en_o, 0);
    check("R8 hsync idle",   hsync_o == 0,   hsync_o,   0);
    rd(3'd5, d);
    check("R9 irq pending", d[0] == 1, d[0], 1);
    wr(3'd5, 32'h0000_0000);
    rd(3'd5, d);
    check("R9 write 0 ignored", d[0] == 1, d[0], 1);
    wr(3'd5, 32'h0000_0001);
    rd(3'd5, d);
    check("R9 write 1 clears", d[0] == 0, d[0], 0);
    check("R9 irq_o low", irq_o == 0, irq_o, 0);

    // R8 restart begins at pixel 0, line 0
    wr(3'd0, 32'h0000_0003);
    check("R8 restart hsync", hsync_o == 1, hsync_o, 1);
    check("R8 restart vsync", vsync_o == 1, vsync_o, 1);
    @(negedge clk_i);
    check("R9 irq after start", irq_o == 1, irq_o, 1);
    wr(3'd0, 32'h0000_0000);

    // R4: invert all, idle levels show inversion
    wr(3'd1, 32'h0000_000F);
    check("R4 hsync idle inverted", hsync_o == 1, hsync_o, 1);
    check("R4 vsync idle inverted", vsync_o == 1, vsync_o, 1);
    check("R4 de idle inverted",    de_o == 1,    de_o,    1);
    check("R4 vclk idle inverted",  vclk_o == 1,  vclk_o,  1);
    // ratio 3
    wr(3'd0, 32'h0000_0203);
    count_win(462, hs, vs, de, pe, ck);
    check("R5 ratio 3 strobes",  pe == 154, pe, 154);
    check("R4 vclk inverted",    ck == 308, ck, 308);
    check("R4 de inverted",      de == 318, de, 318);
    check("R4 hsync inverted",   hs == 378, hs, 378);

    // R6 clamp
    wr(3'd0, 32'h0000_FF00);
    rd(3'd0, d);
    check("R6 divider clamped", d[15:8] == 8'd254, d[15:8], 254);
    wr(3'd0, 32'h0000_C800);
    rd(3'd0, d);
    check("R6 divider in range", d[15:8] == 8'd200, d[15:8], 200);
    wr(3'd1, 32'h0000_0000);
    wr(3'd0, 32'h0000_FF03);
    count_win(510, hs, vs, de, pe, ck);
    check("R6 ratio 255 strobes", pe == 2, pe, 2);
    wr(3'd0, 32'h0000_0000);
    repeat (4) @(negedge clk_i);

    summary();
    $finish;
  end
endmodule